// File: doc/BRIEF.md
# Parallel Panel Bus Window-Setup Engine

This block is the master side of an 8080-style parallel bus that connects to an external display controller. It drives chip select, write strobe, read strobe, a command/data select line and a 16-bit output data lane, and it reads one byte lane back. Each bus access lasts a fixed number of clocks. Inside that slot the strobe edges fall at clock offsets that are set by parameters.

A window request carries a start corner, a width, a height and a two-bit controller variant. The engine sends the window-setup command byte and then an 18-byte descriptor, one byte per access, on the low data byte. When the last byte has gone out it raises a one-cycle done pulse and sets a pixel-mode flag. The flag tells the downstream pixel pump that the bus is now 16 bits wide. A register-read request sends one command byte, runs one read access and returns the byte sampled at the access-time point.

Both requests use a valid/ready handshake. A request is taken on a clock edge where valid and ready are both high. The requester must hold valid and its fields steady until that edge. Ready is high only while the bus is idle, and the read port also loses ready whenever a window request is pending. The read response is a one-cycle pulse with no back-pressure, so the consumer must take it in the cycle it appears.

Top module: `ppb_window_engine`

## Requirements
- R1: After reset, bus_cs_n, bus_wr_n and bus_rd_n are high, win_ready is high, and pix_mode and win_done are low.
- R2: An accepted window request produces exactly 19 write accesses. The first carries 0x6C with bus_dc low. The other 18 carry the descriptor with bus_dc high. In every one of these accesses bus_dout[15:8] is zero.
- R3: Descriptor bytes 0 to 7 are x start, y start, x end and y end in that order, each low byte first. End equals start plus size minus one, modulo 2^16.
- R4: Descriptor bytes 8 to 15 repeat bytes 0 to 7, and byte 16 is 0x01.
- R5: Descriptor byte 17 is 0x00 when the variant sampled at acceptance is 1 or 2, and 0x01 when it is 0 or 3.
- R6: Each access lasts CYC clocks. bus_wr_n is low for WR_OFF-WR_ON clocks per write, and bus_rd_n is low for RD_OFF-RD_ON clocks per read. bus_cs_n is low whenever a strobe is low, and the two strobes are never low together.
- R7: A read request produces one command write with bus_dc low, carrying rd_cmd. It is followed by one read access with bus_dc high. rsp_valid pulses for one cycle CYC+RD_ACC+1 cycles after acceptance, and rsp_data then equals bus_din as sampled at the edge that ends phase RD_ACC-1.
- R8: win_done is a single-cycle pulse seen 19*CYC+1 cycles after acceptance. pix_mode is high from that cycle on.
- R9: win_ready and rd_ready are low while a transaction runs. When both requests are valid in the same cycle, the window request is taken first and the read request afterwards.
- R10: pix_mode drops to low in the cycle after any request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_valid | input | 1 | Window request valid |
| win_ready | output | 1 | Window request ready |
| win_x | input | 16 | Window start column |
| win_y | input | 16 | Window start row |
| win_w | input | 16 | Window width |
| win_h | input | 16 | Window height |
| win_variant | input | 2 | Controller variant selecting the source code |
| rd_valid | input | 1 | Register read request valid |
| rd_ready | output | 1 | Register read request ready |
| rd_cmd | input | 8 | Register address sent as the command byte |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 8 | Read response byte |
| win_done | output | 1 | Descriptor sent, bus now in pixel mode (pulse) |
| pix_mode | output | 1 | High when the bus is configured 16 bits wide |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Low for command, high for data |
| bus_oe | output | 1 | High while the engine drives the data lane |
| bus_dout | output | 16 | Output data lane |
| bus_din | input | 8 | Read data lane |

## Verification
The assertions check the following on every cycle: the strobes never overlap, chip select covers every strobe, the read sample point lies inside the read strobe, done and the read response are single pulses, done coincides with pixel mode, and acceptance clears pixel mode. Only the bench scenarios can show that the descriptor bytes are right for each corner, size, wrap-around and variant. The same holds for strobe widths, the exact latencies of done and read data, and the order in which simultaneous requests are served.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    ACC_CMD   = 2'd0,
    ACC_WDATA = 2'd1,
    ACC_READ  = 2'd2
  } ppb_acc_e;

  localparam int unsigned DESC_LEN   = 18;
  localparam logic [7:0]  WIN_CMD    = 8'h6C;
  localparam logic [7:0]  FMT_RGB565 = 8'h01;

  // source-select code by controller variant
  function automatic logic [7:0] src_code(input logic [1:0] v);
    return (v == 2'd1 || v == 2'd2) ? 8'h00 : 8'h01;
  endfunction
endpackage

// File: rtl/ppb_strobe_timer.sv
module ppb_strobe_timer
  import ppb_pkg::*;
#(
  parameter int unsigned CYC    = 4,
  parameter int unsigned WR_ON  = 1,
  parameter int unsigned WR_OFF = 2,
  parameter int unsigned RD_ON  = 1,
  parameter int unsigned RD_OFF = 3,
  parameter int unsigned RD_ACC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  ppb_acc_e kind,
  output logic     wr_n,
  output logic     rd_n,
  output logic     cap,
  output logic     last
);
  localparam int unsigned PH_W = $clog2(CYC + 1);

  logic [PH_W-1:0] ph;
  logic wr_win, rd_win;

  assign last   = run && (ph == PH_W'(CYC - 1));
  assign wr_win = (ph >= PH_W'(WR_ON)) && (ph < PH_W'(WR_OFF));
  assign rd_win = (ph >= PH_W'(RD_ON)) && (ph < PH_W'(RD_OFF));
  assign wr_n   = !(run && kind != ACC_READ && wr_win);
  assign rd_n   = !(run && kind == ACC_READ && rd_win);
  assign cap    = run && kind == ACC_READ && (ph == PH_W'(RD_ACC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph <= '0;
    else if (run) ph <= last ? '0 : ph + 1'b1;
  end

  // R6: phase stays inside the access slot
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ph < PH_W'(CYC));
  // R7: the sample point falls inside the read strobe
  a_r7_cap_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !rd_n);
  // R6: a new access begins at phase zero
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (ph == '0));
endmodule

// File: rtl/ppb_win_desc.sv
module ppb_win_desc
  import ppb_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] k,
  input  logic [15:0]      x0,
  input  logic [15:0]      y0,
  input  logic [15:0]      x1,
  input  logic [15:0]      y1,
  input  logic [1:0]       variant,
  output logic [7:0]       byte_o
);
  logic [15:0] corner [4];
  logic [15:0] sel;

  always_comb begin
    corner[0] = x0;
    corner[1] = y0;
    corner[2] = x1;
    corner[3] = y1;
    sel       = corner[k[2:1]];
    if (k < IDX_W'(16))      byte_o = k[0] ? sel[15:8] : sel[7:0];
    else if (k == IDX_W'(16)) byte_o = FMT_RGB565;
    else                      byte_o = src_code(variant);
  end
endmodule

// File: rtl/ppb_window_engine.sv
module ppb_window_engine
  import ppb_pkg::*;
#(
  parameter int unsigned CYC    = 4,
  parameter int unsigned WR_ON  = 1,
  parameter int unsigned WR_OFF = 2,
  parameter int unsigned RD_ON  = 1,
  parameter int unsigned RD_OFF = 3,
  parameter int unsigned RD_ACC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_valid,
  output logic        win_ready,
  input  logic [15:0] win_x,
  input  logic [15:0] win_y,
  input  logic [15:0] win_w,
  input  logic [15:0] win_h,
  input  logic [1:0]  win_variant,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [7:0]  rd_cmd,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        win_done,
  output logic        pix_mode,
  output logic        bus_cs_n,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_dc,
  output logic        bus_oe,
  output logic [15:0] bus_dout,
  input  logic [7:0]  bus_din
);
  localparam int unsigned IDX_W = $clog2(DESC_LEN + 1);

  logic             busy, is_win;
  logic [IDX_W-1:0] idx, end_idx, desc_k;
  logic [15:0]      xs, ys, xe, ye;
  logic [1:0]       var_q;
  logic [7:0]       cmd_q, desc_byte, out_byte;
  ppb_acc_e         kind;
  logic             cap, last;

  assign win_ready = !busy;
  assign rd_ready  = !busy && !win_valid;
  assign end_idx   = is_win ? IDX_W'(DESC_LEN) : IDX_W'(1);
  assign desc_k    = idx - 1'b1;
  assign kind      = (idx == '0) ? ACC_CMD : (is_win ? ACC_WDATA : ACC_READ);

  ppb_strobe_timer #(
    .CYC(CYC), .WR_ON(WR_ON), .WR_OFF(WR_OFF),
    .RD_ON(RD_ON), .RD_OFF(RD_OFF), .RD_ACC(RD_ACC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .kind(kind),
    .wr_n(bus_wr_n), .rd_n(bus_rd_n), .cap(cap), .last(last)
  );

  ppb_win_desc #(.IDX_W(IDX_W)) u_desc (
    .k(desc_k), .x0(xs), .y0(ys), .x1(xe), .y1(ye),
    .variant(var_q), .byte_o(desc_byte)
  );

  assign out_byte = (idx == '0) ? cmd_q : desc_byte;
  assign bus_oe   = busy && kind != ACC_READ;
  assign bus_dout = bus_oe ? {8'h00, out_byte} : 16'h0000;
  assign bus_dc   = busy && idx != '0;
  assign bus_cs_n = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; is_win <= 1'b0; idx <= '0;
      xs <= '0; ys <= '0; xe <= '0; ye <= '0;
      var_q <= '0; cmd_q <= '0;
      pix_mode <= 1'b0; win_done <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      win_done  <= 1'b0;
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (win_valid) begin
          busy <= 1'b1; is_win <= 1'b1; idx <= '0; pix_mode <= 1'b0;
          xs <= win_x; ys <= win_y;
          xe <= win_x + win_w - 16'd1;
          ye <= win_y + win_h - 16'd1;
          var_q <= win_variant; cmd_q <= WIN_CMD;
        end else if (rd_valid) begin
          busy <= 1'b1; is_win <= 1'b0; idx <= '0; pix_mode <= 1'b0;
          cmd_q <= rd_cmd;
        end
      end else begin
        if (cap) begin
          rsp_valid <= 1'b1;
          rsp_data  <= bus_din;
        end
        if (last) begin
          if (idx == end_idx) begin
            busy <= 1'b0;
            if (is_win) begin
              win_done <= 1'b1;
              pix_mode <= 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R6: strobes exclusive and always under chip select
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  a_r6_cs_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);
  // R9: handshake only while the bus is idle
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (win_ready || rd_ready) |-> bus_cs_n);
  // R8: done is one cycle and coincides with pixel mode
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
  a_r8_done_pix: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> pix_mode);
  // R7: response is one cycle
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: acceptance drops pixel mode
  a_r10_pix_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_valid && win_ready) || (rd_valid && rd_ready)) |=> !pix_mode);
endmodule

// File: tb/ppb_window_engine_test.sv
`timescale 1ns/1ps
module ppb_window_engine_test;
  localparam int CYC = 4, WR_ON = 1, WR_OFF = 2, RD_ON = 1, RD_OFF = 3, RD_ACC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic win_valid = 1'b0, rd_valid = 1'b0;
  logic [15:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
  logic [1:0]  win_variant = '0;
  logic [7:0]  rd_cmd = '0;
  logic win_ready, rd_ready, rsp_valid, win_done, pix_mode;
  logic [7:0] rsp_data, bus_din;
  logic bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, bus_oe;
  logic [15:0] bus_dout;

  always #2.5 clk = ~clk;

  ppb_window_engine uut (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_ready(win_ready),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .win_variant(win_variant),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_cmd(rd_cmd),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .win_done(win_done), .pix_mode(pix_mode),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_dc(bus_dc), .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  int compared = 0, mismatched = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // panel-side model: logs writes, measures strobe widths, answers reads
  logic [16:0] wlog [256];
  int wcnt = 0, rcnt = 0, wlow = 0, rlow = 0, bad_wr = 0, bad_rd = 0, rd_dc_bad = 0;
  logic [7:0] resp = 8'h00;
  assign bus_din = bus_rd_n ? 8'hFF : resp;

  always @(negedge clk) begin
    if (!bus_wr_n) wlow++;
    else begin
      if (wlow != 0) begin
        wlog[wcnt[7:0]] = {bus_dc, bus_dout};
        wcnt++;
        if (wlow != WR_OFF - WR_ON) bad_wr++;
        if (!bus_dc) resp = bus_dout[7:0] ^ 8'h5A;
      end
      wlow = 0;
    end
    if (!bus_rd_n) begin
      rlow++;
      if (!bus_dc) rd_dc_bad++;
    end else begin
      if (rlow != 0) begin
        rcnt++;
        if (rlow != RD_OFF - RD_ON) bad_rd++;
      end
      rlow = 0;
    end
  end

  function automatic logic [7:0] exp_b(input int i, input logic [15:0] x, y, w, h,
                                       input logic [1:0] v);
    logic [15:0] c [4];
    c[0] = x; c[1] = y; c[2] = x + w - 16'd1; c[3] = y + h - 16'd1;
    if (i < 16) return ((i % 2) == 1) ? c[(i % 8) / 2][15:8] : c[(i % 8) / 2][7:0];
    if (i == 16) return 8'h01;
    return (v == 2'd1 || v == 2'd2) ? 8'h00 : 8'h01;
  endfunction

  // {x, y, w, h, variant}
  localparam logic [65:0] VEC [4] = '{
    {16'd0,    16'd0,    16'd800,  16'd480,  2'd1},
    {16'h00FF, 16'h0001, 16'd2,    16'd1,    2'd2},
    {16'h1234, 16'h0F0F, 16'd1,    16'd1,    2'd0},
    {16'hFFF0, 16'h0100, 16'h0020, 16'h0200, 2'd3}
  };

  task automatic run_window(input logic [15:0] x, y, w, h, input logic [1:0] v,
                            input bit with_read);
    int base, bw0, n;
    @(negedge clk);
    win_x = x; win_y = y; win_w = w; win_h = h; win_variant = v; win_valid = 1'b1;
    if (with_read) begin rd_valid = 1'b1; rd_cmd = 8'h0A; end
    #0.1;
    if (with_read) check("R9 read ready with window pending", {31'd0, rd_ready}, 32'd0);
    base = wcnt; bw0 = bad_wr; n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin
        win_valid = 1'b0;
        check("R9 win_ready while busy", {31'd0, win_ready}, 32'd0);
      end
    end while (!win_done && n < 2000);
    check("R8 done latency", n, 19 * CYC + 1);
    check("R8 pix_mode at done", {31'd0, pix_mode}, 32'd1);
    check("R2 write count", wcnt - base, 19);
    check("R2 command byte", {15'd0, wlog[base[7:0]]}, {15'd0, 1'b0, 16'h006C});
    for (int i = 0; i < 18; i++) begin
      string tg;
      tg = (i < 8) ? "R3 descriptor byte" : (i < 17) ? "R4 descriptor byte" : "R5 source code";
      check(tg, {15'd0, wlog[(base + 1 + i) % 256]}, {15'd0, 1'b1, 8'h00, exp_b(i, x, y, w, h, v)});
    end
    check("R6 write strobe width", bad_wr - bw0, 0);
    @(negedge clk);
    if (with_read) rd_valid = 1'b0;
    check("R8 done single pulse", {31'd0, win_done}, 32'd0);
  endtask

  task automatic run_read(input logic [7:0] cmd);
    int base, br0, rc0, n;
    @(negedge clk);
    rd_cmd = cmd; rd_valid = 1'b1;
    base = wcnt; br0 = bad_rd; rc0 = rcnt; n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin
        rd_valid = 1'b0;
        check("R10 pix_mode cleared on accept", {31'd0, pix_mode}, 32'd0);
      end
    end while (!rsp_valid && n < 2000);
    check("R7 read latency", n, CYC + RD_ACC + 1);
    check("R7 read data", {24'd0, rsp_data}, {24'd0, cmd ^ 8'h5A});
    repeat (3) @(negedge clk);
    check("R7 one command write", wcnt - base, 1);
    check("R7 command byte", {15'd0, wlog[base[7:0]]}, {15'd0, 1'b0, 8'h00, cmd});
    check("R7 one read access", rcnt - rc0, 1);
    check("R7 dc high during read", rd_dc_bad, 0);
    check("R6 read strobe width", bad_rd - br0, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n", {31'd0, bus_cs_n}, 32'd1);
    check("R1 wr_n", {31'd0, bus_wr_n}, 32'd1);
    check("R1 rd_n", {31'd0, bus_rd_n}, 32'd1);
    check("R1 win_ready", {31'd0, win_ready}, 32'd1);
    check("R1 pix_mode", {31'd0, pix_mode}, 32'd0);
    check("R1 win_done", {31'd0, win_done}, 32'd0);

    foreach (VEC[i])
      run_window(VEC[i][65:50], VEC[i][49:34], VEC[i][33:18], VEC[i][17:2], VEC[i][1:0], 1'b0);

    // pixel mode holds while idle (R8), then a read clears it (R10)
    repeat (5) @(negedge clk);
    check("R8 pix_mode held", {31'd0, pix_mode}, 32'd1);
    run_read(8'h00);
    run_read(8'h02);

    // simultaneous requests: window first, then read (R9)
    run_window(16'h0010, 16'h0020, 16'h0004, 16'h0003, 2'd1, 1'b1);
    begin
      int n = 0;
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      check("R9 deferred read data", {24'd0, rsp_data}, {24'd0, 8'h0A ^ 8'h5A});
    end
    repeat (4) @(negedge clk);
    check("R9 idle after both", {31'd0, win_ready}, 32'd1);
    finish_run();
  end
endmodule